// File: doc/BRIEF.md
# Memory Sub-Channel Performance Counter Unit

This unit collects performance statistics for one DRAM sub-channel on the controller clock. On each cycle it takes command strobes from the host side of the memory controller: read, write and read-modify-write. It also takes a valid-qualified access with its rank and bank-group tags, and a vector of retry pulses, one per uncorrectable-error class. It keeps a bank of counters in four groups. The groups are a 64-bit free-running cycle counter, eight bandwidth counters, ten retry counters and sixteen common counters whose event is chosen by software.

Software uses a word-addressed register port to set a global enable, fire a one-shot clear of every counter, and pick the bandwidth mode and the target rank. Through the same port it programs the event for each common counter, reads every count and clears sticky wrap flags. Each bandwidth count stands for one 64-byte transfer. Events are counted per command, never per data beat.

Top module: `pmu_top`

## Requirements
- R1: After reset every counter, every wrap flag, the control register (address 0x00) and every event select (0x30+i) read as zero.
- R2: While the enable bit (CTRL bit 0) is set, the 64-bit cycle counter advances by one per clock. Reading its low half at 0x01 with regRdEn latches the high half, which then reads at 0x02.
- R3: When the enable bit is clear, no counter changes.
- R4: Common counter i (count at 0x20+i) counts according to its 5-bit select at 0x30+i. The select values are 0 none, 1 read, 2 write, 3 read-modify-write, 4 all three command kinds, 5 any valid access and 6 all retry pulses. Other values count nothing.
- R5: When several strobes selected for the same counter arrive in one cycle, the counter adds one for each strobe (select 4 adds up to 3, select 6 adds up to 10).
- R6: With CTRL bit 2 at 0, bandwidth counter g (0x08+g) counts valid accesses whose bank group is g and whose rank equals CTRL bits 5:4.
- R7: With CTRL bit 2 at 1, bandwidth counter r (r in 0..3) counts valid accesses to rank r, and counters 4..7 hold their value.
- R8: Retry counter k (0x10+k) counts pulses on retryPulse[k].
- R9: Writing CTRL with bit 1 set zeroes every counter at that clock edge. This takes priority over any event in the same cycle, and bit 1 reads back as 0.
- R10: Counters wrap to the remainder modulo 2^CNT_W. A wrap sets a sticky flag in the overflow registers (0x04 bits 31:0, 0x05 bits 2:0). The flags are ordered cycle 0, bandwidth 1..8, retry 9..18, common 19..34. Writing a 1 to a flag bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller core clock |
| rstN | input | 1 | Active-low synchronous reset |
| evRd | input | 1 | Host read command strobe |
| evWr | input | 1 | Host write command strobe |
| evRmw | input | 1 | Host read-modify-write command strobe |
| accValid | input | 1 | Access tag valid |
| accRank | input | 2 | Rank of the access |
| accBankGroup | input | 3 | Bank group of the access |
| retryPulse | input | 10 | One pulse per uncorrectable-error retry class |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (needed for the cycle-low latch) |
| regAddr | input | 6 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational on regAddr |

## Verification
A software clear and a counted event can arrive in the same clock. The bench provokes this by writing CTRL with the clear bit while a read strobe is asserted for a counter already holding a nonzero count. It then expects that counter to read zero, not one, and to count normally from the next strobe on. A second collision comes from a select-4 counter that sees read, write and read-modify-write in one cycle, which must add three.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_BW     = 8;
  localparam int NUM_RETRY  = 10;
  localparam int NUM_COMMON = 16;
  localparam int NUM_FLAGS  = 1 + NUM_BW + NUM_RETRY + NUM_COMMON;
  localparam int SEL_W      = 5;
  localparam int INC_W      = 4;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 6;
  localparam int RANK_W     = 2;
  localparam int BG_W       = 3;
  localparam int CYC_W      = 64;

  localparam int FLAG_BW     = 1;
  localparam int FLAG_RETRY  = FLAG_BW + NUM_BW;
  localparam int FLAG_COMMON = FLAG_RETRY + NUM_RETRY;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_CYC_LO = 6'h01;
  localparam logic [ADDR_W-1:0] A_CYC_HI = 6'h02;
  localparam logic [ADDR_W-1:0] A_OVF_LO = 6'h04;
  localparam logic [ADDR_W-1:0] A_OVF_HI = 6'h05;
  localparam int BW_BASE    = 'h08;
  localparam int RETRY_BASE = 'h10;
  localparam int COM_BASE   = 'h20;
  localparam int SEL_BASE   = 'h30;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE  = 5'd0,
    SEL_RD    = 5'd1,
    SEL_WR    = 5'd2,
    SEL_RMW   = 5'd3,
    SEL_CMDS  = 5'd4,
    SEL_ACC   = 5'd5,
    SEL_RETRY = 5'd6
  } evtSel_e;

  typedef struct packed {
    logic                 enable;
    logic                 clear;
    logic                 bwMode;
    logic [RANK_W-1:0]    bwRank;
    logic [NUM_FLAGS-1:0] flagClr;
  } ctlStrobes_t;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W    = 32,
  parameter int IN_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clr,
  input  logic [IN_W-1:0] incAmt,
  input  logic            flagClr,
  output logic [W-1:0]    cnt,
  output logic            ovf
);
  logic [W:0] sum;
  logic [W:0] incExt;

  always_comb begin
    incExt = '0;
    incExt[IN_W-1:0] = incAmt;
    sum = {1'b0, cnt} + incExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)    cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 ovf <= 1'b0;
    else if (!clr && sum[W])   ovf <= 1'b1;
    else if (flagClr)          ovf <= 1'b0;
  end

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0));

  // R10
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ((cnt >= $past(cnt)) || ovf));
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  regWrEn,
  input  logic                                  regRdEn,
  input  logic [ADDR_W-1:0]                     regAddr,
  input  logic [DATA_W-1:0]                     regWrData,
  output logic [DATA_W-1:0]                     regRdData,
  output ctlStrobes_t                           ctl,
  output logic [NUM_COMMON*SEL_W-1:0]           evtSelFlat,
  input  logic [CYC_W-1:0]                      cycCnt,
  input  logic [NUM_BW-1:0][CNT_W-1:0]          bwCnt,
  input  logic [NUM_RETRY-1:0][CNT_W-1:0]       retryCnt,
  input  logic [NUM_COMMON-1:0][CNT_W-1:0]      comCnt,
  input  logic [NUM_FLAGS-1:0]                  ovfFlags
);
  logic              enableReg;
  logic              bwModeReg;
  logic [RANK_W-1:0] bwRankReg;
  logic [DATA_W-1:0] cycHiShadow;
  logic [NUM_COMMON-1:0][SEL_W-1:0] evtSel;
  logic              ctrlWr;
  logic              cycLoRd;
  logic [2*DATA_W-1:0] flagMask;

  assign ctrlWr  = regWrEn && (regAddr == A_CTRL);
  assign cycLoRd = regRdEn && (regAddr == A_CYC_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      bwModeReg <= 1'b0;
      bwRankReg <= '0;
    end else if (ctrlWr) begin
      enableReg <= regWrData[0];
      bwModeReg <= regWrData[2];
      bwRankReg <= regWrData[4 +: RANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        cycHiShadow <= '0;
    else if (cycLoRd) cycHiShadow <= cycCnt[CYC_W-1:DATA_W];
  end

  for (genvar i = 0; i < NUM_COMMON; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rstN) evtSel[i] <= '0;
      else if (regWrEn && (regAddr == ADDR_W'(SEL_BASE + i)))
        evtSel[i] <= regWrData[SEL_W-1:0];
    end
    assign evtSelFlat[i*SEL_W +: SEL_W] = evtSel[i];
  end

  always_comb begin
    flagMask = '0;
    if (regWrEn && regAddr == A_OVF_LO) flagMask[DATA_W-1:0] = regWrData;
    if (regWrEn && regAddr == A_OVF_HI) flagMask[2*DATA_W-1:DATA_W] = regWrData;
  end

  always_comb begin
    ctl.enable  = enableReg;
    ctl.clear   = ctrlWr && regWrData[1];
    ctl.bwMode  = bwModeReg;
    ctl.bwRank  = bwRankReg;
    ctl.flagClr = flagMask[NUM_FLAGS-1:0];
  end

  always_comb begin
    logic [2*DATA_W-1:0] flagExt;
    flagExt = '0;
    flagExt[NUM_FLAGS-1:0] = ovfFlags;
    regRdData = '0;
    case (regAddr)
      A_CTRL: begin
        regRdData[0] = enableReg;
        regRdData[2] = bwModeReg;
        regRdData[4 +: RANK_W] = bwRankReg;
      end
      A_CYC_LO: regRdData = cycCnt[DATA_W-1:0];
      A_CYC_HI: regRdData = cycHiShadow;
      A_OVF_LO: regRdData = flagExt[DATA_W-1:0];
      A_OVF_HI: regRdData = flagExt[2*DATA_W-1:DATA_W];
      default: ;
    endcase
    for (int i = 0; i < NUM_BW; i++)
      if (regAddr == ADDR_W'(BW_BASE + i)) regRdData[CNT_W-1:0] = bwCnt[i];
    for (int i = 0; i < NUM_RETRY; i++)
      if (regAddr == ADDR_W'(RETRY_BASE + i)) regRdData[CNT_W-1:0] = retryCnt[i];
    for (int i = 0; i < NUM_COMMON; i++) begin
      if (regAddr == ADDR_W'(COM_BASE + i)) regRdData[CNT_W-1:0] = comCnt[i];
      if (regAddr == ADDR_W'(SEL_BASE + i)) regRdData[SEL_W-1:0] = evtSel[i];
    end
  end

  // R2
  hi_shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cycLoRd |=> $stable(cycHiShadow));
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ctlStrobes_t                           ctl,
  input  logic [NUM_COMMON*SEL_W-1:0]           evtSelFlat,
  input  logic                                  evRd,
  input  logic                                  evWr,
  input  logic                                  evRmw,
  input  logic                                  accValid,
  input  logic [RANK_W-1:0]                     accRank,
  input  logic [BG_W-1:0]                       accBankGroup,
  input  logic [NUM_RETRY-1:0]                  retryPulse,
  output logic [CYC_W-1:0]                      cycCnt,
  output logic [NUM_BW-1:0][CNT_W-1:0]          bwCnt,
  output logic [NUM_RETRY-1:0][CNT_W-1:0]       retryCnt,
  output logic [NUM_COMMON-1:0][CNT_W-1:0]      comCnt,
  output logic [NUM_FLAGS-1:0]                  ovfFlags
);
  localparam int RANK_SLOTS = 1 << RANK_W;

  pmu_counter #(.W(CYC_W), .IN_W(1)) u_cyc (
    .clk(clk), .rstN(rstN), .clr(ctl.clear), .incAmt(ctl.enable),
    .flagClr(ctl.flagClr[0]), .cnt(cycCnt), .ovf(ovfFlags[0])
  );

  for (genvar g = 0; g < NUM_BW; g++) begin : g_bw
    logic hit;
    always_comb begin
      if (ctl.bwMode)
        hit = (g < RANK_SLOTS) && (accRank == RANK_W'(g));
      else
        hit = (accRank == ctl.bwRank) && (accBankGroup == BG_W'(g));
    end
    pmu_counter #(.W(CNT_W), .IN_W(1)) u_bw (
      .clk(clk), .rstN(rstN), .clr(ctl.clear),
      .incAmt(ctl.enable && accValid && hit),
      .flagClr(ctl.flagClr[FLAG_BW+g]), .cnt(bwCnt[g]), .ovf(ovfFlags[FLAG_BW+g])
    );
    if (g >= RANK_SLOTS) begin : g_idle
      // R7
      rank_mode_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.bwMode && !ctl.clear) |=> $stable(bwCnt[g]));
    end
  end

  for (genvar k = 0; k < NUM_RETRY; k++) begin : g_retry
    pmu_counter #(.W(CNT_W), .IN_W(1)) u_rt (
      .clk(clk), .rstN(rstN), .clr(ctl.clear),
      .incAmt(ctl.enable && retryPulse[k]),
      .flagClr(ctl.flagClr[FLAG_RETRY+k]), .cnt(retryCnt[k]),
      .ovf(ovfFlags[FLAG_RETRY+k])
    );
  end

  for (genvar c = 0; c < NUM_COMMON; c++) begin : g_com
    logic [INC_W-1:0] inc;
    logic [SEL_W-1:0] sel;
    assign sel = evtSelFlat[c*SEL_W +: SEL_W];
    always_comb begin
      inc = '0;
      if (ctl.enable) begin
        case (sel)
          SEL_RD:    inc = INC_W'(evRd);
          SEL_WR:    inc = INC_W'(evWr);
          SEL_RMW:   inc = INC_W'(evRmw);
          SEL_CMDS:  inc = INC_W'(evRd) + INC_W'(evWr) + INC_W'(evRmw);
          SEL_ACC:   inc = INC_W'(accValid);
          SEL_RETRY: inc = INC_W'($countones(retryPulse));
          default:   inc = '0;
        endcase
      end
    end
    pmu_counter #(.W(CNT_W), .IN_W(INC_W)) u_com (
      .clk(clk), .rstN(rstN), .clr(ctl.clear), .incAmt(inc),
      .flagClr(ctl.flagClr[FLAG_COMMON+c]), .cnt(comCnt[c]),
      .ovf(ovfFlags[FLAG_COMMON+c])
    );
  end

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.enable && !ctl.clear) |=> $stable(cycCnt));
endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evRd,
  input  logic                 evWr,
  input  logic                 evRmw,
  input  logic                 accValid,
  input  logic [RANK_W-1:0]    accRank,
  input  logic [BG_W-1:0]      accBankGroup,
  input  logic [NUM_RETRY-1:0] retryPulse,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData
);
  ctlStrobes_t ctl;
  logic [NUM_COMMON*SEL_W-1:0]      evtSelFlat;
  logic [CYC_W-1:0]                 cycCnt;
  logic [NUM_BW-1:0][CNT_W-1:0]     bwCnt;
  logic [NUM_RETRY-1:0][CNT_W-1:0]  retryCnt;
  logic [NUM_COMMON-1:0][CNT_W-1:0] comCnt;
  logic [NUM_FLAGS-1:0]             ovfFlags;

  pmu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .ctl(ctl), .evtSelFlat(evtSelFlat), .cycCnt(cycCnt), .bwCnt(bwCnt),
    .retryCnt(retryCnt), .comCnt(comCnt), .ovfFlags(ovfFlags)
  );

  pmu_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .evtSelFlat(evtSelFlat),
    .evRd(evRd), .evWr(evWr), .evRmw(evRmw), .accValid(accValid),
    .accRank(accRank), .accBankGroup(accBankGroup), .retryPulse(retryPulse),
    .cycCnt(cycCnt), .bwCnt(bwCnt), .retryCnt(retryCnt), .comCnt(comCnt),
    .ovfFlags(ovfFlags)
  );
endmodule

// File: tb/tb_pmu_top.sv
module tb_pmu_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evRd = 0, evWr = 0, evRmw = 0, accValid = 0;
  logic [1:0] accRank = '0;
  logic [2:0] accBankGroup = '0;
  logic [9:0] retryPulse = '0;
  logic regWrEn = 0, regRdEn = 0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pmu_top #(.CNT_W(8)) dut (
    .clk(clk), .rstN(rstN), .evRd(evRd), .evWr(evWr), .evRmw(evRmw),
    .accValid(accValid), .accRank(accRank), .accBankGroup(accBankGroup),
    .retryPulse(retryPulse), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(logic r, logic w, logic m, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evRd = r; evWr = w; evRmw = m;
      @(negedge clk);
      evRd = 0; evWr = 0; evRmw = 0;
    end
  endtask

  task automatic access(logic [1:0] rk, logic [2:0] bg, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      accValid = 1; accRank = rk; accBankGroup = bg;
      @(negedge clk);
      accValid = 0;
    end
  endtask

  task automatic retries(logic [9:0] v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      retryPulse = v;
      @(negedge clk);
      retryPulse = '0;
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(6'h00, d); chk("R1 ctrl", d, 0);
    rd(6'h01, d); chk("R1 cycle low", d, 0);
    rd(6'h20, d); chk("R1 common0", d, 0);
    rd(6'h0F, d); chk("R1 bw7", d, 0);
    rd(6'h04, d); chk("R1 flags", d, 0);
    rd(6'h3F, d); chk("R1 select15", d, 0);
  endtask

  task automatic testCycle();
    logic [31:0] a, b;
    wr(6'h00, 32'h3);
    @(negedge clk);
    regAddr = 6'h01; regRdEn = 1;
    #1 a = regRdData;
    @(negedge clk);
    regRdEn = 0;
    regAddr = 6'h02;
    #1 chk("R2 high latch", regRdData, 0);
    repeat (4) @(negedge clk);
    regAddr = 6'h01;
    #1 b = regRdData;
    chk("R2 cycle delta", b - a, 5);
  endtask

  task automatic testCommon();
    logic [31:0] d;
    wr(6'h30, 1); wr(6'h31, 2); wr(6'h32, 3); wr(6'h33, 4); wr(6'h34, 0);
    wr(6'h35, 9);
    wr(6'h00, 32'h3);
    pulse(1, 0, 0, 3);
    pulse(0, 1, 0, 2);
    pulse(0, 0, 1, 1);
    rd(6'h20, d); chk("R4 read sel", d, 3);
    rd(6'h21, d); chk("R4 write sel", d, 2);
    rd(6'h22, d); chk("R4 rmw sel", d, 1);
    rd(6'h24, d); chk("R4 select 0 idle", d, 0);
    rd(6'h25, d); chk("R4 unused select idle", d, 0);
    pulse(1, 1, 1, 2);
    rd(6'h23, d); chk("R5 all commands", d, 12);
    rd(6'h20, d); chk("R5 read in burst", d, 5);
  endtask

  task automatic testBankGroup();
    logic [31:0] d;
    wr(6'h00, 32'h23);
    access(2, 5, 3);
    access(2, 0, 1);
    access(1, 5, 2);
    rd(6'h0D, d); chk("R6 bg5", d, 3);
    rd(6'h08, d); chk("R6 bg0", d, 1);
    rd(6'h09, d); chk("R6 bg1", d, 0);
  endtask

  task automatic testRank();
    logic [31:0] d;
    wr(6'h00, 32'h07);
    access(3, 7, 2);
    access(0, 6, 1);
    rd(6'h0B, d); chk("R7 rank3", d, 2);
    rd(6'h08, d); chk("R7 rank0", d, 1);
    rd(6'h0F, d); chk("R7 slot7 idle", d, 0);
    rd(6'h0E, d); chk("R7 slot6 idle", d, 0);
  endtask

  task automatic testRetry();
    logic [31:0] d;
    wr(6'h00, 32'h3);
    retries(10'h201, 2);
    retries(10'h004, 1);
    rd(6'h10, d); chk("R8 retry0", d, 2);
    rd(6'h19, d); chk("R8 retry9", d, 2);
    rd(6'h12, d); chk("R8 retry2", d, 1);
    rd(6'h11, d); chk("R8 retry1", d, 0);
  endtask

  task automatic testClearCollide();
    logic [31:0] d;
    wr(6'h30, 1);
    wr(6'h00, 32'h1);
    pulse(1, 0, 0, 3);
    @(negedge clk);
    regWrEn = 1; regAddr = 6'h00; regWrData = 32'h3; evRd = 1;
    @(negedge clk);
    regWrEn = 0; evRd = 0;
    rd(6'h20, d); chk("R9 clear beats event", d, 0);
    rd(6'h00, d); chk("R9 clear bit reads 0", d, 1);
    pulse(1, 0, 0, 1);
    rd(6'h20, d); chk("R9 counts after clear", d, 1);
  endtask

  task automatic testDisable();
    logic [31:0] d, a;
    wr(6'h00, 32'h0);
    rd(6'h01, a);
    pulse(1, 0, 0, 2);
    rd(6'h20, d); chk("R3 common held", d, 1);
    rd(6'h01, d); chk("R3 cycle held", d, a);
  endtask

  task automatic testWrap();
    logic [31:0] d;
    wr(6'h30, 6);
    wr(6'h00, 32'h3);
    retries(10'h3FF, 26);
    rd(6'h20, d); chk("R10 wrapped value", d, 4);
    rd(6'h04, d); chk("R10 flag19 set", d & 32'h0008_0000, 32'h0008_0000);
    wr(6'h04, 32'h0008_0000);
    rd(6'h04, d); chk("R10 flag19 cleared", d & 32'h0008_0000, 0);
    rd(6'h05, d); chk("R10 high flags clear", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testCycle();
    testCommon();
    testBankGroup();
    testRank();
    testRetry();
    testClearCollide();
    testDisable();
    testWrap();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule